// File: doc/BRIEF.md
# Packed-Integer Instruction Fault Checker

This block decides, from one snapshot of processor control state, whether a packed-integer shuffle-class instruction may execute or which single fault it has to raise. Rules differ by operand class. The 128-bit vector form needs extra enables and strict 16-byte operand alignment. The 64-bit legacy vector form can raise a math fault for a pending floating-point exception and an alignment-check fault for user-mode accesses.

The result is purely combinational. An issue stage presents the instruction's class, the relevant control bits, the memory-operand flag, the effective address and the mode. In the same cycle it reads back a one-hot fault vector and a no-fault flag. When several conditions hold together, only the most urgent one is reported. Page faults and segment-limit checks are handled elsewhere.

Top module: `simd_fault_check`

## Requirements
- R1: An undefined-opcode fault (faultVec bit 0) is reported when crEmul is 1 or lockPfx is 1, for either operand class.
- R2: With isWide=1, an undefined-opcode fault is also reported when osSaveEn is 0 or vecCapable is 0. With isWide=0, these two bits have no effect on the outputs.
- R3: A device-not-available fault (faultVec bit 1) is reported when crTaskSw is 1.
- R4: With isWide=1 and memOp=1, an effective address whose bits [3:0] are not all zero raises general protection (faultVec bit 2) in every opMode. With memOp=0, the address is ignored.
- R5: In real mode (opMode=0), memOp=1 together with realRangeErr=1 raises general protection. In any other mode, realRangeErr has no effect.
- R6: In 64-bit mode (opMode=2), memOp=1 with a non-canonical address raises general protection. An address is non-canonical when bits [63:47] are not all equal.
- R7: With isWide=0, fpPending=1 raises a math fault (faultVec bit 3). With isWide=1, fpPending has no effect.
- R8: With isWide=0, an alignment-check fault (faultVec bit 4) is raised only when all of the following hold: memOp=1, alignChkEn=1, cpl=3, and address bits [2:0] are not all zero. The 16-byte rule of R4 never applies to this class.
- R9: faultVec is at most one-hot. When several faults apply, only the first in the order undefined opcode, device not available, general protection, math fault, alignment check is reported. opMode=3 behaves as protected mode (opMode=1).
- R10: noFault is 1 exactly when faultVec is all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| isWide | input | 1 | Operand class: 1 = 128-bit vector, 0 = 64-bit legacy vector |
| crEmul | input | 1 | Emulation control bit |
| crTaskSw | input | 1 | Task-switched control bit |
| osSaveEn | input | 1 | OS support for extended state save |
| vecCapable | input | 1 | Vector extension present |
| lockPfx | input | 1 | Lock prefix present on the instruction |
| memOp | input | 1 | Source operand is in memory |
| effAddr | input | ADDR_W (64) | Effective address of the memory operand |
| opMode | input | 2 | 0 real, 1 protected, 2 64-bit, 3 treated as protected |
| realRangeErr | input | 1 | Real-mode operand crosses outside 0..FFFFh |
| fpPending | input | 1 | Pending legacy floating-point exception |
| alignChkEn | input | 1 | Alignment checking enabled |
| cpl | input | 2 | Current privilege level |
| faultVec | output | 5 | One-hot fault: bit0 UD, bit1 NM, bit2 GP, bit3 MF, bit4 AC |
| noFault | output | 1 | Instruction may execute |

## Verification
Each result is due in the cycle its stimulus is applied, because no register lies between any input and either output. The bench changes inputs on the falling clock edge and reads both outputs one nanosecond later, so every check sees values settled from the current stimulus and never a value from the previous one. A table of directed cases covers each rule and the pairwise priority conflicts. It is followed by an exhaustive sweep of every control-bit combination, all four mode codes and four representative addresses, each compared against a reference model that the bench builds from the requirements.

// File: rtl/shuf_fault_pkg.sv
package shuf_fault_pkg;

  typedef enum logic [1:0] {
    MODE_REAL = 2'd0,
    MODE_PROT = 2'd1,
    MODE_LONG = 2'd2,
    MODE_RSVD = 2'd3
  } opMode_e;

  // fault vector bit positions, lowest index is highest priority
  localparam int FAULT_N = 5;
  localparam int FLT_UD  = 0;
  localparam int FLT_NM  = 1;
  localparam int FLT_GP  = 2;
  localparam int FLT_MF  = 3;
  localparam int FLT_AC  = 4;

  localparam logic [1:0] USER_CPL = 2'd3;

  // strobes from control decode into the address/priority datapath
  typedef struct packed {
    logic udHit;
    logic nmHit;
    logic mfHit;
    logic chkWideAlign;
    logic chkLegacyAlign;
    logic chkRealRange;
    logic chkCanon;
  } ctrlStrobe_t;

endpackage

// File: rtl/fault_cond_ctrl.sv
module fault_cond_ctrl
  import shuf_fault_pkg::*;
(
  input  logic        isWide,
  input  logic        crEmul,
  input  logic        crTaskSw,
  input  logic        osSaveEn,
  input  logic        vecCapable,
  input  logic        lockPfx,
  input  logic        memOp,
  input  logic [1:0]  opMode,
  input  logic        fpPending,
  input  logic        alignChkEn,
  input  logic [1:0]  cpl,
  output ctrlStrobe_t stb
);

  opMode_e modeDec;
  logic    wideGate;
  logic    userAc;

  always_comb begin
    modeDec  = opMode_e'(opMode);
    // the 128-bit form needs both the OS save support and the capability bit
    wideGate = isWide & (~osSaveEn | ~vecCapable);
    userAc   = alignChkEn & (cpl == USER_CPL);

    stb                = '0;
    stb.udHit          = crEmul | lockPfx | wideGate;
    stb.nmHit          = crTaskSw;
    stb.mfHit          = ~isWide & fpPending;
    stb.chkWideAlign   = isWide & memOp;
    stb.chkLegacyAlign = ~isWide & memOp & userAc;
    stb.chkRealRange   = memOp & (modeDec == MODE_REAL);
    stb.chkCanon       = memOp & (modeDec == MODE_LONG);
  end

  // R7: a wide operand never asks for a math fault
  always_comb begin
    if (isWide) begin
      a_r7_wide_no_mf: assert (!stb.mfHit) else $error("mf strobe on wide class");
    end
  end

endmodule

// File: rtl/fault_addr_path.sv
module fault_addr_path
  import shuf_fault_pkg::*;
#(
  parameter int ADDR_W       = 64,
  parameter int VA_W         = 48,
  parameter int WIDE_BYTES   = 16,
  parameter int LEGACY_BYTES = 8
) (
  input  ctrlStrobe_t        stb,
  input  logic [ADDR_W-1:0]  effAddr,
  input  logic               realRangeErr,
  output logic [FAULT_N-1:0] faultVec,
  output logic               noFault
);

  localparam int WIDE_LSB = $clog2(WIDE_BYTES);
  localparam int LEG_LSB  = $clog2(LEGACY_BYTES);
  localparam int HI_W     = ADDR_W - VA_W + 1;

  logic [HI_W-1:0]    addrHigh;
  logic               nonCanon;
  logic               wideMis;
  logic               legMis;
  logic [FAULT_N-1:0] rawVec;

  always_comb begin
    addrHigh = effAddr[ADDR_W-1:VA_W-1];
    nonCanon = ~((addrHigh == '0) | (addrHigh == '1));
    wideMis  = |effAddr[WIDE_LSB-1:0];
    legMis   = |effAddr[LEG_LSB-1:0];

    rawVec         = '0;
    rawVec[FLT_UD] = stb.udHit;
    rawVec[FLT_NM] = stb.nmHit;
    rawVec[FLT_GP] = (stb.chkWideAlign & wideMis)
                   | (stb.chkRealRange & realRangeErr)
                   | (stb.chkCanon & nonCanon);
    rawVec[FLT_MF] = stb.mfHit;
    rawVec[FLT_AC] = stb.chkLegacyAlign & legMis;
  end

  // priority pick: a bit survives only if every lower index is clear
  genvar gi;
  generate
    for (gi = 0; gi < FAULT_N; gi++) begin : g_prio
      if (gi == 0) begin : g_top
        assign faultVec[gi] = rawVec[gi];
      end else begin : g_rest
        assign faultVec[gi] = rawVec[gi] & ~(|rawVec[gi-1:0]);
      end
    end
  endgenerate

  assign noFault = ~(|faultVec);

  always_comb begin
    a_r9_onehot: assert ($onehot0(faultVec)) else $error("fault vector not one-hot");
    if (stb.udHit) begin
      a_r1_ud_first: assert (faultVec == 5'b00001) else $error("UD did not win");
    end
    if (!stb.udHit && stb.nmHit) begin
      a_r3_nm_second: assert (faultVec == 5'b00010) else $error("NM did not win");
    end
    if (noFault) begin
      a_r10_clean: assert (!stb.udHit && !stb.nmHit && !stb.mfHit)
        else $error("noFault with active strobe");
    end
  end

endmodule

// File: rtl/simd_fault_check.sv
module simd_fault_check
  import shuf_fault_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int VA_W   = 48
) (
  input  logic              isWide,
  input  logic              crEmul,
  input  logic              crTaskSw,
  input  logic              osSaveEn,
  input  logic              vecCapable,
  input  logic              lockPfx,
  input  logic              memOp,
  input  logic [ADDR_W-1:0] effAddr,
  input  logic [1:0]        opMode,
  input  logic              realRangeErr,
  input  logic              fpPending,
  input  logic              alignChkEn,
  input  logic [1:0]        cpl,
  output logic [4:0]        faultVec,
  output logic              noFault
);

  ctrlStrobe_t stb;

  fault_cond_ctrl u_ctrl (
    .isWide     (isWide),
    .crEmul     (crEmul),
    .crTaskSw   (crTaskSw),
    .osSaveEn   (osSaveEn),
    .vecCapable (vecCapable),
    .lockPfx    (lockPfx),
    .memOp      (memOp),
    .opMode     (opMode),
    .fpPending  (fpPending),
    .alignChkEn (alignChkEn),
    .cpl        (cpl),
    .stb        (stb)
  );

  fault_addr_path #(
    .ADDR_W       (ADDR_W),
    .VA_W         (VA_W),
    .WIDE_BYTES   (16),
    .LEGACY_BYTES (8)
  ) u_path (
    .stb          (stb),
    .effAddr      (effAddr),
    .realRangeErr (realRangeErr),
    .faultVec     (faultVec),
    .noFault      (noFault)
  );

endmodule

// File: tb/simd_fault_check_tb.sv
module simd_fault_check_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        isWide, crEmul, crTaskSw, osSaveEn, vecCapable, lockPfx, memOp;
  logic [63:0] effAddr;
  logic [1:0]  opMode, cpl;
  logic        realRangeErr, fpPending, alignChkEn;
  logic [4:0]  faultVec;
  logic        noFault;

  int total = 0;
  int bad   = 0;
  int cycles = 0;
  bit done  = 0;

  always #2 clk = ~clk;

  simd_fault_check u_dut (
    .isWide(isWide), .crEmul(crEmul), .crTaskSw(crTaskSw), .osSaveEn(osSaveEn),
    .vecCapable(vecCapable), .lockPfx(lockPfx), .memOp(memOp), .effAddr(effAddr),
    .opMode(opMode), .realRangeErr(realRangeErr), .fpPending(fpPending),
    .alignChkEn(alignChkEn), .cpl(cpl), .faultVec(faultVec), .noFault(noFault)
  );

  // stim bits: wide emul ts os cap lock mem mode[2] realErr fp acEn cpl[2]
  localparam int NV = 18;
  localparam logic [82:0] VEC [NV] = '{
    {14'b1_0_0_1_1_0_1_01_0_0_0_00, 64'h1000, 5'b00000},                 // R4 aligned
    {14'b1_0_0_1_1_0_1_01_0_0_0_00, 64'h1008, 5'b00100},                 // R4 misaligned
    {14'b1_0_0_0_1_0_0_01_0_0_0_00, 64'h0, 5'b00001},                    // R2 no os save
    {14'b0_0_0_0_0_0_0_01_0_0_0_00, 64'h0, 5'b00000},                    // R2 legacy ignores
    {14'b0_0_0_1_1_0_0_01_0_1_0_00, 64'h0, 5'b01000},                    // R7 mf
    {14'b1_0_0_1_1_0_0_01_0_1_0_00, 64'h0, 5'b00000},                    // R7 wide ignores
    {14'b0_0_0_1_1_0_1_01_0_0_1_11, 64'h1004, 5'b10000},                 // R8 ac
    {14'b0_0_0_1_1_0_1_01_0_0_1_11, 64'h1008, 5'b00000},                 // R8 no 16B rule
    {14'b0_0_0_1_1_0_1_01_0_0_1_00, 64'h1004, 5'b00000},                 // R8 cpl0
    {14'b0_0_0_1_1_0_1_10_0_0_0_00, 64'h0000_8000_0000_0000, 5'b00100},  // R6 noncanon
    {14'b0_0_0_1_1_0_1_10_0_0_0_00, 64'hFFFF_8000_0000_0000, 5'b00000},  // R6 canon
    {14'b0_0_0_1_1_0_1_00_1_0_0_00, 64'h10, 5'b00100},                   // R5 real
    {14'b0_0_0_1_1_0_1_01_1_0_0_00, 64'h10, 5'b00000},                   // R5 prot ignores
    {14'b0_1_1_1_1_0_0_01_0_1_0_00, 64'h0, 5'b00001},                    // R9 ud>nm>mf
    {14'b0_0_1_1_1_0_0_01_0_1_0_00, 64'h0, 5'b00010},                    // R3 nm>mf
    {14'b0_0_0_1_1_0_1_10_0_1_0_00, 64'h0000_8000_0000_0000, 5'b00100},  // R9 gp>mf
    {14'b0_0_0_1_1_0_1_01_0_1_1_11, 64'h1004, 5'b01000},                 // R9 mf>ac
    {14'b1_0_0_1_1_1_0_01_0_0_0_00, 64'h0, 5'b00001}                     // R1 lock
  };

  function automatic logic [4:0] refFault(input logic [13:0] s, input logic [63:0] a);
    logic w, e, t, o, c, l, m, r, f, ae;
    logic [1:0] md, pl;
    logic [4:0] raw;
    logic nc;
    {w, e, t, o, c, l, m, md, r, f, ae, pl} = s;
    nc = !((a[63:47] == 17'h0) || (a[63:47] == 17'h1FFFF));
    raw[0] = e | l | (w & (!o | !c));
    raw[1] = t;
    raw[2] = m & ((w & (a[3:0] != 0)) | ((md == 2'd0) & r) | ((md == 2'd2) & nc));
    raw[3] = !w & f;
    raw[4] = !w & m & ae & (pl == 2'd3) & (a[2:0] != 0);
    if (raw[0]) return 5'b00001;
    if (raw[1]) return 5'b00010;
    if (raw[2]) return 5'b00100;
    if (raw[3]) return 5'b01000;
    if (raw[4]) return 5'b10000;
    return 5'b00000;
  endfunction

  function automatic string reqOf(input logic [4:0] e);
    case (e)
      5'b00001: return "R1/R2";
      5'b00010: return "R3";
      5'b00100: return "R4/R5/R6";
      5'b01000: return "R7";
      5'b10000: return "R8";
      default:  return "R9";
    endcase
  endfunction

  task automatic apply(input logic [13:0] s, input logic [63:0] a);
    @(negedge clk);
    {isWide, crEmul, crTaskSw, osSaveEn, vecCapable, lockPfx, memOp,
     opMode, realRangeErr, fpPending, alignChkEn, cpl} = s;
    effAddr = a;
    #1;
  endtask

  task automatic check(input logic [4:0] exp, input string req);
    total++;
    if (faultVec !== exp) begin
      bad++;
      $display("FAIL %s faultVec actual=%b expected=%b", req, faultVec, exp);
    end
    total++;
    if (noFault !== (exp == 5'b0)) begin
      bad++;
      $display("FAIL R10 noFault actual=%b expected=%b", noFault, (exp == 5'b0));
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1;
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [63:0] addrSet [4];
    addrSet[0] = 64'h2000;
    addrSet[1] = 64'h2004;
    addrSet[2] = 64'h2008;
    addrSet[3] = 64'h0001_0000_0000_0000;
    {isWide, crEmul, crTaskSw, osSaveEn, vecCapable, lockPfx, memOp,
     opMode, realRangeErr, fpPending, alignChkEn, cpl} = '0;
    effAddr = '0;
    repeat (3) @(posedge clk);
    rstN = 1'b1;
    // reset state: idle legacy inputs give no fault (R10)
    apply(14'b0, 64'h0);
    check(5'b00000, "R10 reset");

    for (int i = 0; i < NV; i++) begin
      apply(VEC[i][82:69], VEC[i][68:5]);
      check(VEC[i][4:0], reqOf(VEC[i][4:0]));
    end

    // exhaustive sweep over control bits, modes and addresses (R1..R9)
    for (int s = 0; s < (1 << 14); s++) begin
      for (int k = 0; k < 4; k++) begin
        logic [4:0] exp;
        apply(14'(s), addrSet[k]);
        exp = refFault(14'(s), addrSet[k]);
        check(exp, reqOf(exp));
      end
    end

    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule